// File: doc/BRIEF.md
# Host Command Serial Slave

This block is the device end of a clocked serial link driven by an external host controller. The host raises a high-active select (`ce`), toggles `sck` and presents bits on `sdi`. The block answers on `sdo`, which can be push-pull or released to high impedance while the select is low. It also drives a low-active busy line. Every transfer opens with a mode byte. The first six bits are a code, sent MSB first. The seventh bit gives the direction. During the eighth bit the slave reports acknowledge (low) or refusal (high). After an acknowledge, the transfer carries either command bytes from the host or data bytes to the host, each sent MSB first.

Inside the chip, the block offers received command bytes through a valid/ready pair and takes outgoing bytes through a second valid/ready pair. A FIFO can sit on either side. The serial pins are brought into the `clk` domain through synchronizers. The block then acts on detected `sck` edges: it samples on the rising edge and changes `sdo` on the falling edge. A byte is `DATA_W` bits, and `DATA_W` must equal `CODE_W + 2`.

The controller has seven states:
- IDLE waits for select.
- MODE collects the code and the direction bit.
- REFUSED is entered after a refusal and holds until select drops.
- CMD shifts in a command byte.
- CMD_WAIT offers a completed byte inside the chip.
- RD_FETCH asks for the next outgoing byte.
- RD shifts that byte out.

Transitions:
- IDLE→MODE when select rises.
- MODE→CMD, MODE→RD_FETCH or MODE→REFUSED on the eighth rising edge, chosen by the code match and the direction bit.
- CMD→CMD_WAIT and RD→RD_FETCH on the eighth rising edge of a byte.
- CMD_WAIT→CMD when the byte is accepted.
- RD_FETCH→RD when a byte is supplied.
- Any state→IDLE when select goes low.

Top module: `host_sio_slave`

## Requirements
- R1: After reset, `busy_n`=1, `sdo`=1, `cmd_valid`=0 and `rd_ready`=0.
- R2: When the six code bits received MSB first equal `mode_code`, `sdo` is 0 for the eighth bit of the mode byte. With direction bit 0, each following group of eight bits is presented on `cmd_data` MSB first (the first bit sent lands in bit 7) together with `cmd_valid`=1.
- R3: When the code differs, `sdo` stays 1 for the eighth bit. No command byte is then offered, no outgoing byte is requested and `sdo` stays 1 for all further clocks, until `ce` is lowered and raised again.
- R4: With direction bit 1, `rd_ready`=1 and `busy_n`=0 until a byte is supplied through `rd_valid`. Its bit 7 is then on `sdo`, and the following bits appear one per falling `sck` edge, down to bit 0.
- R5: After each complete command byte, `busy_n` is 0 and `cmd_valid`/`cmd_data` hold steady until `cmd_ready` is seen. Then `busy_n` returns to 1 and `cmd_valid` to 0.
- R6: Lowering `ce` in the middle of a byte returns the block to IDLE and discards the partial bits. No command byte is offered, `busy_n`=1, and the next transfer starts cleanly.
- R7: With `tristate_en`=1, `sdo_oe` is 0 while `ce` is low and 1 while it is high. With `tristate_en`=0, `sdo_oe` is always 1.
- R8: `sdo` changes only after a falling `sck` edge while a byte is being sent. A rising edge, at which the host samples, leaves it unchanged.
- R9: Several bytes of the same direction may follow one mode byte, each with its own busy phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, low active |
| mode_code | input | CODE_W | Code that the mode byte must match |
| tristate_en | input | 1 | 1: release `sdo` while select is low |
| ce | input | 1 | Host select, high active |
| sck | input | 1 | Host serial clock |
| sdi | input | 1 | Host serial data to the slave |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| busy_n | output | 1 | Busy, low active |
| cmd_data | output | DATA_W | Received command byte |
| cmd_valid | output | 1 | Command byte offered |
| cmd_ready | input | 1 | Command byte accepted |
| rd_data | input | DATA_W | Outgoing byte |
| rd_valid | input | 1 | Outgoing byte supplied |
| rd_ready | output | 1 | Outgoing byte requested |

## Verification
The bench aims at the acknowledge slot. A design that compared the code one bit off, or put the answer on the wrong clock, would show the host a wrong ACK or NACK. After a refusal, the bench keeps clocking data. A slave that failed to lock out would start offering bytes. The bench lowers select halfway through a byte and checks that the next byte arrives intact, which catches leftover bits or a counter that was not cleared. For reads, it samples `sdo` both before and after each rising edge, so a slave that shifted on the wrong edge, or lost bit 7 at load time, would return a corrupted byte.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_MODE     = 3'd1,
        ST_CMD      = 3'd2,
        ST_CMD_WAIT = 3'd3,
        ST_RD_FETCH = 3'd4,
        ST_RD       = 3'd5,
        ST_REFUSED  = 3'd6
    } sio_state_t;

endpackage

// File: rtl/sio_sync.sv
// Multi-stage synchronizer for one asynchronous pin.
module sio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sio_shifter.sv
// Shared shift register: serial in at LSB, parallel load, left shift.
module sio_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (load)     q <= load_val;
        else if (shift_en) q <= {q[W-2:0], ser_in};
    end
endmodule

// File: rtl/host_sio_slave.sv
module host_sio_slave
    import sio_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mode_code,
    input  logic              tristate_en,
    input  logic              ce,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy_n,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              rd_ready
);
    localparam int CNT_W     = $clog2(DATA_W) + 1;
    localparam int MODE_LAST = CODE_W + 1;   // rising edges before the ack bit
    localparam int N_SYNC    = 3;

    // pin synchronizers: index 2 = ce, 1 = sck, 0 = sdi
    logic [N_SYNC-1:0] pin_raw, pin_s;
    assign pin_raw = {ce, sck, sdi};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw[g]),
            .q     (pin_s[g])
        );
    end

    logic ce_s, sck_s, sdi_s, sck_d;
    assign ce_s  = pin_s[2];
    assign sck_s = pin_s[1];
    assign sdi_s = pin_s[0];

    logic sck_rise, sck_fall;
    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    sio_state_t       st, nxt;
    logic [CNT_W-1:0] bitcnt;
    logic             sdo_q;

    // shared byte shifter
    logic [DATA_W-1:0] sh;
    logic              sh_load, sh_shift, sh_in;
    logic              code_match, dir_read;

    assign code_match = (sh[CODE_W:1] == mode_code);
    assign dir_read   = sh[0];

    assign sh_load  = (st == ST_RD_FETCH) && rd_valid && ce_s;
    assign sh_shift = ce_s && ((sck_rise && (st == ST_MODE || st == ST_CMD)) ||
                               (sck_fall && st == ST_RD && bitcnt != '0));
    assign sh_in    = (st == ST_RD) ? 1'b0 : sdi_s;

    sio_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (rd_data),
        .shift_en (sh_shift),
        .ser_in   (sh_in),
        .q        (sh)
    );

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:     if (ce_s) nxt = ST_MODE;
            ST_MODE:     if (sck_rise && bitcnt == CNT_W'(MODE_LAST)) begin
                             if (!code_match)  nxt = ST_REFUSED;
                             else if (dir_read) nxt = ST_RD_FETCH;
                             else              nxt = ST_CMD;
                         end
            ST_CMD:      if (sck_rise && bitcnt == CNT_W'(DATA_W-1)) nxt = ST_CMD_WAIT;
            ST_CMD_WAIT: if (cmd_ready) nxt = ST_CMD;
            ST_RD_FETCH: if (rd_valid)  nxt = ST_RD;
            ST_RD:       if (sck_rise && bitcnt == CNT_W'(DATA_W-1)) nxt = ST_RD_FETCH;
            ST_REFUSED:  nxt = ST_REFUSED;
            default:     nxt = ST_IDLE;
        endcase
        if (!ce_s) nxt = ST_IDLE;
    end

    // state register, bit counter, serial output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            sdo_q  <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            st    <= nxt;
            sck_d <= sck_s;

            if (!ce_s || nxt != st)
                bitcnt <= '0;
            else if (sck_rise && (st == ST_MODE || st == ST_CMD || st == ST_RD))
                bitcnt <= bitcnt + 1'b1;

            if (!ce_s)
                sdo_q <= 1'b1;
            else if (sh_load)
                sdo_q <= rd_data[DATA_W-1];
            else if (sck_fall) begin
                if (st == ST_MODE && bitcnt == CNT_W'(MODE_LAST))
                    sdo_q <= ~code_match;
                else if (st == ST_CMD)
                    sdo_q <= 1'b1;
                else if (st == ST_RD && bitcnt != '0)
                    sdo_q <= sh[DATA_W-2];
            end
        end
    end

    // outputs
    always_comb begin
        cmd_valid = (st == ST_CMD_WAIT);
        rd_ready  = (st == ST_RD_FETCH);
        busy_n    = !(st == ST_CMD_WAIT || st == ST_RD_FETCH);
        sdo_oe    = ~tristate_en | ce_s;
        sdo       = sdo_q;
        cmd_data  = sh;
    end
endmodule

// File: rtl/sio_checker.sv
module sio_checker
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input sio_state_t        st,
    input logic              ce_s,
    input logic              sck_fall,
    input logic              sdo,
    input logic              busy_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [DATA_W-1:0] cmd_data,
    input logic              rd_ready
);
    // R5: an offered byte stays put until it is taken
    a_r5_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && ce_s |=> cmd_valid && $stable(cmd_data));

    // R5: busy is shown while a byte is offered
    a_r5_busy_offer: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !busy_n);

    // R4: busy is shown while an outgoing byte is awaited
    a_r4_busy_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> !busy_n && !cmd_valid);

    // R8: while sending, sdo moves only on a falling sck edge
    a_r8_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD) && ce_s && !sck_fall |=> $stable(sdo));

    // R3: a refused transfer stays silent
    a_r3_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REFUSED) |-> sdo && busy_n && !cmd_valid && !rd_ready);

    // R6: select low ends every handshake
    a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !cmd_valid && !rd_ready && busy_n);
endmodule

bind host_sio_slave sio_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .ce_s      (ce_s),
    .sck_fall  (sck_fall),
    .sdo       (sdo),
    .busy_n    (busy_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .rd_ready  (rd_ready)
);

// File: tb/host_sio_slave_test.sv
`timescale 1ns/1ps
module host_sio_slave_test;
    localparam int HALF = 80;
    localparam logic [5:0] CODE = 6'b101101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] mode_code = CODE;
    logic       tristate_en = 1'b0;
    logic       ce = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic       sdo, sdo_oe, busy_n, cmd_valid, rd_ready;
    logic [7:0] cmd_data;
    logic       cmd_ready = 1'b0;
    logic [7:0] rd_data = '0;
    logic       rd_valid = 1'b0;

    int checks = 0;
    int fails  = 0;
    int valid_cycles = 0;

    always #5 clk = ~clk;

    host_sio_slave uut (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .tristate_en(tristate_en),
        .ce(ce), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .busy_n(busy_n),
        .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    always @(posedge clk) if (cmd_valid) valid_cycles++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        sdi = b;
        #HALF;
        r = sdo;
        sck = 1'b1;
        #HALF;
        sck = 1'b0;
    endtask

    task automatic start_mode(input logic [5:0] code, input logic dir, output logic ack);
        logic r;
        ce = 1'b1;
        #60;
        for (int i = 5; i >= 0; i--) xfer_bit(code[i], r);
        xfer_bit(dir, r);
        xfer_bit(1'b0, ack);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) xfer_bit(b[i], r);
    endtask

    task automatic end_xfer();
        #50;
        ce = 1'b0;
        #100;
    endtask

    task automatic take_cmd(input logic [7:0] exp, input string req);
        #100;
        chk(cmd_valid == 1'b1, req, "cmd_valid after byte", cmd_valid, 1);
        chk(busy_n == 1'b0, "R5", "busy_n during offer", busy_n, 0);
        chk(cmd_data == exp, req, "cmd_data", cmd_data, exp);
        #100;
        chk(cmd_valid == 1'b1 && cmd_data == exp, "R5", "offer held", cmd_data, exp);
        @(negedge clk) cmd_ready = 1'b1;
        @(negedge clk) cmd_ready = 1'b0;
        #30;
        chk(busy_n == 1'b1 && cmd_valid == 1'b0, "R5", "busy released", busy_n, 1);
    endtask

    task automatic give_rd(input logic [7:0] d, input string req);
        #100;
        chk(rd_ready == 1'b1 && busy_n == 1'b0, req, "fetch request with busy", {rd_ready, busy_n}, 2);
        @(negedge clk) begin rd_data = d; rd_valid = 1'b1; end
        @(negedge clk) rd_valid = 1'b0;
        #30;
        chk(busy_n == 1'b1 && rd_ready == 1'b0, req, "busy released after supply", busy_n, 1);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input string req);
        logic [7:0] got;
        logic r1, r2;
        bit steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sdi = 1'b0;
            #HALF;
            r1 = sdo;
            sck = 1'b1;
            #(HALF - 20);
            r2 = sdo;
            #20;
            sck = 1'b0;
            got[i] = r1;
            if (r1 !== r2) steady = 1'b0;
        end
        chk(got == exp, req, "read byte", got, exp);
        chk(steady, "R8", "sdo steady across rising edge", steady, 1);
    endtask

    task automatic t_reset();
        chk(busy_n == 1'b1, "R1", "busy_n", busy_n, 1);
        chk(sdo == 1'b1, "R1", "sdo", sdo, 1);
        chk(cmd_valid == 1'b0 && rd_ready == 1'b0, "R1", "handshakes idle", {cmd_valid, rd_ready}, 0);
    endtask

    task automatic t_write();
        logic ack;
        start_mode(CODE, 1'b0, ack);
        chk(ack == 1'b0, "R2", "ack on write", ack, 0);
        send_byte(8'hA5);
        take_cmd(8'hA5, "R2");
        send_byte(8'h3C);
        take_cmd(8'h3C, "R9");
        end_xfer();
    endtask

    task automatic t_nack();
        logic ack, r;
        int v0;
        bit high = 1'b1;
        start_mode(CODE ^ 6'b000100, 1'b0, ack);
        chk(ack == 1'b1, "R3", "nack on wrong code", ack, 1);
        v0 = valid_cycles;
        for (int i = 0; i < 8; i++) begin
            xfer_bit(1'b1, r);
            if (r !== 1'b1) high = 1'b0;
        end
        #100;
        chk(valid_cycles == v0, "R3", "no command offered after nack", valid_cycles - v0, 0);
        chk(high && busy_n && !rd_ready, "R3", "sdo high and idle after nack", {high, busy_n, rd_ready}, 6);
        end_xfer();
        start_mode(CODE, 1'b0, ack);
        chk(ack == 1'b0, "R3", "ack after reselect", ack, 0);
        send_byte(8'h42);
        take_cmd(8'h42, "R3");
        end_xfer();
    endtask

    task automatic t_read();
        logic ack;
        start_mode(CODE, 1'b1, ack);
        chk(ack == 1'b0, "R4", "ack on read", ack, 0);
        give_rd(8'hC6, "R4");
        chk(sdo == 1'b1, "R4", "bit 7 present at load", sdo, 1);
        recv_byte(8'hC6, "R4");
        give_rd(8'h5A, "R9");
        recv_byte(8'h5A, "R9");
        end_xfer();
    endtask

    task automatic t_abort();
        logic ack, r;
        int v0;
        start_mode(CODE, 1'b0, ack);
        v0 = valid_cycles;
        for (int i = 0; i < 4; i++) xfer_bit(1'b1, r);
        end_xfer();
        chk(valid_cycles == v0 && busy_n == 1'b1, "R6", "partial byte dropped", valid_cycles - v0, 0);
        start_mode(CODE, 1'b0, ack);
        chk(ack == 1'b0, "R6", "ack after abort", ack, 0);
        send_byte(8'h81);
        take_cmd(8'h81, "R6");
        end_xfer();
    endtask

    task automatic t_tristate();
        tristate_en = 1'b1;
        #100;
        chk(sdo_oe == 1'b0, "R7", "released while deselected", sdo_oe, 0);
        ce = 1'b1;
        #100;
        chk(sdo_oe == 1'b1, "R7", "driven while selected", sdo_oe, 1);
        ce = 1'b0;
        #100;
        chk(sdo_oe == 1'b0, "R7", "released again", sdo_oe, 0);
        tristate_en = 1'b0;
        #20;
        chk(sdo_oe == 1'b1, "R7", "push-pull drives while deselected", sdo_oe, 1);
        #100;
    endtask

    initial begin
        #500_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #33 rst_n = 1'b1;
        #50;
        t_reset();
        t_write();
        t_nack();
        t_read();
        t_abort();
        t_tristate();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule